// File: doc/BRIEF.md
# Accumulator Logic and Bit-Test Unit

This block performs the bitwise side of an 8-bit accumulator datapath. Each enabled clock it takes an operand that has already been fetched, combines it with the current accumulator under one of three logic operations (AND, exclusive-OR, inclusive-OR), and registers both the new accumulator and a status byte with refreshed zero and negative flags. A fourth operation, the bit test, probes the operand against the accumulator without disturbing it. It reports whether the two share any set bit, and it copies the two top operand bits into the negative and overflow flags.

The surrounding core supplies the accumulator and status byte it currently holds, selects the operation, and raises the enable for one cycle per instruction. The registered outputs are written back into the core's architectural state. Address generation, memory access and instruction decode sit outside this block.

Top module: `acc_bitlogic_unit`

## Requirements
- R1: With enable high and op_sel = 2'b00 at a rising edge, acc_out becomes acc_in AND operand on that edge.
- R2: With enable high and op_sel = 2'b01 at a rising edge, acc_out becomes acc_in XOR operand on that edge.
- R3: With enable high and op_sel = 2'b10 at a rising edge, acc_out becomes acc_in OR operand on that edge.
- R4: After op_sel 2'b00, 2'b01 or 2'b10, status bit 1 (zero) is 1 exactly when the new acc_out is 8'h00, status bit 7 (negative) equals bit 7 of the new acc_out, and status bit 6 (overflow) equals status_in bit 6.
- R5: With op_sel = 2'b11 (bit test), status bit 1 is 1 exactly when (acc_in AND operand) is 8'h00.
- R6: With op_sel = 2'b11, status bit 7 takes operand bit 7 and status bit 6 takes operand bit 6, whatever acc_in holds.
- R7: With op_sel = 2'b11, acc_out becomes acc_in unchanged.
- R8: Status bits 0 (carry), 2, 3, 4 and 5 are copied from status_in by every enabled operation.
- R9: With enable low at a rising edge, acc_out and status_out keep their values.
- R10: With rst_n low at a rising edge, acc_out and status_out become 8'h00 on that edge, whatever enable holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Perform the selected operation on this edge |
| op_sel | input | 2 | 00 AND, 01 XOR, 10 OR, 11 bit test |
| operand | input | 8 | Fetched memory operand |
| acc_in | input | 8 | Current accumulator value |
| status_in | input | 8 | Current status byte (C bit 0, Z bit 1, V bit 6, N bit 7) |
| acc_out | output | 8 | Registered next accumulator |
| status_out | output | 8 | Registered next status byte |

## Verification
The bench aims at the bit test with operands whose top bits disagree with the accumulator's, where a design that took negative and overflow from the AND result or the accumulator would report the wrong flags, and at an accumulator of zero paired with an operand of 8'hC0, where a design taking zero from the operand alone would clear it. It drives XOR of equal values and AND of disjoint masks to reach a zero result, where a flag derived from the inputs rather than the result would fail. It changes every input while enable is low, exposing a register that loads regardless. It sets overflow in status_in before logic operations and random values in the unused status bits, catching a merge that clears flags it does not own.

// File: rtl/acc_bitlogic_pkg.sv
// Package: shared operation codes and status-byte bit positions for the
// accumulator logic unit. Assumes an 8-bit status byte.
package acc_bitlogic_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_XOR  = 2'b01,
        OP_IOR  = 2'b10,
        OP_TEST = 2'b11
    } logic_op_e;

    localparam int STAT_W = 8;
    localparam int FLG_C  = 0;
    localparam int FLG_Z  = 1;
    localparam int FLG_V  = 6;
    localparam int FLG_N  = 7;

endpackage

// File: rtl/acc_bitlogic_core.sv
// Module: per-bit logic slice array. Produces the value to be written to the
// accumulator and the raw AND of accumulator and operand for the test.
// Assumes the operation code is already decoded into logic_op_e.
module acc_bitlogic_core
    import acc_bitlogic_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic_op_e         op,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] and_bits,
    output logic              is_test
);

    // One slice per bit; the test writes the accumulator back untouched.
    for (genvar b = 0; b < DATA_W; b++) begin : g_slice
        // Selects the per-bit value for the operation in flight.
        always_comb begin
            and_bits[b] = acc[b] & operand[b];
            unique case (op)
                OP_AND:  result[b] = acc[b] & operand[b];
                OP_XOR:  result[b] = acc[b] ^ operand[b];
                OP_IOR:  result[b] = acc[b] | operand[b];
                default: result[b] = acc[b];
            endcase
        end
    end

    // Flags the non-destructive test for the status merge.
    always_comb is_test = (op == OP_TEST);

endmodule

// File: rtl/acc_bitlogic_flags.sv
// Module: status merge. Rewrites zero, negative and overflow as the operation
// requires and passes every other status bit through. Assumes DATA_W >= 2.
module acc_bitlogic_flags
    import acc_bitlogic_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              is_test,
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] and_bits,
    input  logic [DATA_W-1:0] operand,
    input  logic [STAT_W-1:0] status_in,
    output logic [STAT_W-1:0] status_next
);

    localparam int MSB = DATA_W - 1;

    // Builds the next status byte from the unmodified bits plus new flags.
    always_comb begin
        status_next = status_in;
        if (is_test) begin
            status_next[FLG_Z] = (and_bits == '0);
            status_next[FLG_N] = operand[MSB];
            status_next[FLG_V] = operand[MSB-1];
        end else begin
            status_next[FLG_Z] = (result == '0);
            status_next[FLG_N] = result[MSB];
        end
    end

endmodule

// File: rtl/acc_bitlogic_reg.sv
// Module: enabled register with synchronous active-low reset to zero.
// Assumes one load per enabled edge.
module acc_bitlogic_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Clears on reset, loads on enable, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end

    // R9: a disabled edge leaves the stored value alone.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> q == $past(q));

endmodule

// File: rtl/acc_bitlogic_unit.sv
// Module: accumulator logic and bit-test unit top. Computes AND/XOR/OR or the
// bit test on an already fetched operand and registers accumulator and status.
// Assumes the caller feeds back the architectural accumulator and status.
module acc_bitlogic_unit
    import acc_bitlogic_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [7:0]        status_in,
    output logic [DATA_W-1:0] acc_out,
    output logic [7:0]        status_out
);

    localparam int MSB = DATA_W - 1;

    logic_op_e         op;
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] and_bits;
    logic              is_test;
    logic [STAT_W-1:0] status_next;

    // Maps the raw select onto the operation type.
    always_comb op = logic_op_e'(op_sel);

    acc_bitlogic_core #(.DATA_W(DATA_W)) i_core (
        .op       (op),
        .operand  (operand),
        .acc      (acc_in),
        .result   (result),
        .and_bits (and_bits),
        .is_test  (is_test)
    );

    acc_bitlogic_flags #(.DATA_W(DATA_W)) i_flags (
        .is_test     (is_test),
        .result      (result),
        .and_bits    (and_bits),
        .operand     (operand),
        .status_in   (status_in),
        .status_next (status_next)
    );

    acc_bitlogic_reg #(.W(DATA_W)) i_acc_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .d     (result),
        .q     (acc_out)
    );

    acc_bitlogic_reg #(.W(STAT_W)) i_stat_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .d     (status_next),
        .q     (status_out)
    );

    // R1: AND lands in the accumulator.
    p_and_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en && op_sel == 2'b00 |=> acc_out == ($past(acc_in) & $past(operand)));

    // R2: XOR lands in the accumulator.
    p_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en && op_sel == 2'b01 |=> acc_out == ($past(acc_in) ^ $past(operand)));

    // R3: OR lands in the accumulator.
    p_ior_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en && op_sel == 2'b10 |=> acc_out == ($past(acc_in) | $past(operand)));

    // R4: zero and negative follow the registered result; overflow kept.
    p_zn_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && op_sel != 2'b11 |=>
            status_out[FLG_Z] == (acc_out == '0) && status_out[FLG_N] == acc_out[MSB]
            && status_out[FLG_V] == $past(status_in[FLG_V]));

    // R5: test zero flag comes from the shared bits.
    p_test_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en && op_sel == 2'b11 |=>
            status_out[FLG_Z] == (($past(acc_in) & $past(operand)) == '0));

    // R6: test copies the top operand bits into negative and overflow.
    p_test_nv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en && op_sel == 2'b11 |=>
            status_out[FLG_N] == $past(operand[MSB]) && status_out[FLG_V] == $past(operand[MSB-1]));

    // R7: test leaves the accumulator as it was given.
    p_test_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en && op_sel == 2'b11 |=> acc_out == $past(acc_in));

    // R8: unowned status bits pass through.
    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> status_out[FLG_C] == $past(status_in[FLG_C])
            && status_out[5:2] == $past(status_in[5:2]));

endmodule

// File: tb/test_acc_bitlogic_unit.sv
`timescale 1ns/1ps
module test_acc_bitlogic_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] op_sel = 2'b00;
    logic [7:0] operand = 8'h00;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] status_in = 8'h00;
    logic [7:0] acc_out;
    logic [7:0] status_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_acc = 8'h00;
    logic [7:0] m_st  = 8'h00;
    string t_acc = "R10";
    string t_zn  = "R10";
    string t_v   = "R10";

    always #10 clk = ~clk;

    acc_bitlogic_unit i_acc_bitlogic_unit (
        .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel), .operand(operand),
        .acc_in(acc_in), .status_in(status_in), .acc_out(acc_out), .status_out(status_out)
    );

    // Behavioural reference, stepped on every rising edge.
    always @(posedge clk) begin
        logic [7:0] r;
        if (!rst_n) begin
            m_acc = 8'h00; m_st = 8'h00;
            t_acc = "R10"; t_zn = "R10"; t_v = "R10";
        end else if (!en) begin
            t_acc = "R9"; t_zn = "R9"; t_v = "R9";
        end else begin
            m_st = status_in;
            case (op_sel)
                2'b00: begin r = acc_in & operand; t_acc = "R1"; end
                2'b01: begin r = acc_in ^ operand; t_acc = "R2"; end
                2'b10: begin r = acc_in | operand; t_acc = "R3"; end
                default: begin r = acc_in; t_acc = "R7"; end
            endcase
            m_acc = r;
            if (op_sel == 2'b11) begin
                m_st[1] = ((acc_in & operand) == 8'h00);
                m_st[7] = operand[7];
                m_st[6] = operand[6];
                t_zn = "R5"; t_v = "R6";
            end else begin
                m_st[1] = (r == 8'h00);
                m_st[7] = r[7];
                t_zn = "R4"; t_v = "R4";
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Compare away from the edge on every clock.
    always @(negedge clk) begin
        if (!done) begin
            chk(t_acc, acc_out, m_acc);
            chk(t_zn, {status_out[7], 6'b0, status_out[1]}, {m_st[7], 6'b0, m_st[1]});
            chk(t_v, {7'b0, status_out[6]}, {7'b0, m_st[6]});
            chk((t_acc == "R10" || t_acc == "R9") ? t_acc : "R8",
                {2'b0, status_out[5:2], 1'b0, status_out[0]},
                {2'b0, m_st[5:2], 1'b0, m_st[0]});
        end
    end

    task automatic step(input bit e, input logic [1:0] o, input logic [7:0] a,
                        input logic [7:0] d, input logic [7:0] s);
        @(negedge clk);
        en = e; op_sel = o; acc_in = a; operand = d; status_in = s;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1, 2'b00, 8'hF0, 8'h0F, 8'h40);   // R1 disjoint masks: zero, V kept
        step(1, 2'b01, 8'h5A, 8'h5A, 8'h7D);   // R2 equal values -> zero
        step(1, 2'b10, 8'h01, 8'h80, 8'h41);   // R3 negative result
        step(1, 2'b11, 8'h00, 8'hC0, 8'h00);   // R5 R6 R7 zero acc, N V set
        step(1, 2'b11, 8'h01, 8'h3F, 8'hFF);   // R6 top bits clear, overlap
        step(1, 2'b11, 8'hC0, 8'h00, 8'h3C);   // R6 acc top bits must not leak
        step(0, 2'b01, 8'hFF, 8'hAA, 8'h00);   // R9 hold
        step(0, 2'b11, 8'h12, 8'h34, 8'hFF);   // R9 hold
        step(1, 2'b10, 8'h00, 8'h00, 8'hBF);   // R3 R4 zero from OR
        step(1, 2'b11, 8'hAA, 8'h55, 8'h02);   // R5 no overlap
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) != 0, 2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        step(1, 2'b10, 8'h77, 8'h88, 8'hFF);
        @(negedge clk);
        rst_n = 1'b0;                           // R10 reset while enabled
        repeat (2) @(negedge clk);
        rst_n = 1'b1; en = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule